// File: doc/BRIEF.md
# Multi-Context Ready/Execute Scheduler

This block keeps the scheduling state for eight hardware thread contexts of a small processing engine and decides which one of them runs. Each context owns a program counter, a pending-signal mask and a wakeup mask. Software reaches these through a context-select register and a small set of indirect registers. A context is Ready when its pending-signal mask and its wakeup mask share a set bit. It may be dispatched only while its bit in the enable field is set.

When no context is running, the block picks the next Ready, enabled context in round-robin order, starting after the one that ran most recently. It then presents that context and its program counter on the run outputs. The chosen context keeps the engine until it gives it up through a yield strobe, which sends it to Waiting, or a kill strobe, which sends it to Inactive and erases its masks. A Waiting context becomes Ready again when an incoming signal strobe hits its wakeup mask. Clearing an enable bit only blocks later dispatches and never takes the engine away from a running context.

Top module: `ctx_sched`

## Requirements
- R1: After reset no context runs, the active-status register reads 0, the enable field reads 0, and every context's masks and program counter read 0.
- R2: When software writes a matching set bit into both the wakeup mask (offset 0x50) and the pending-signal mask (offset 0x48) of an enabled context on an idle engine, `run_valid` rises on the clock edge after the last of those writes.
- R3: Bits [15:8] of the register at offset 0x18 enable contexts 0 to 7. A Ready context whose bit is clear is never dispatched. Setting the bit while the engine is idle dispatches it on the following edge.
- R4: Among Ready, enabled contexts, the one dispatched is the first one found scanning upward, with wrap, from the index after the most recently dispatched context. After reset, that scan begins at context 0.
- R5: Clearing the enable bit of the running context leaves `run_valid` high and `run_ctx` unchanged until a yield or kill strobe arrives.
- R6: On a yield strobe the running context goes to Waiting. It becomes Ready again only when `sig_in` carries a bit that is also set in its wakeup mask. Signal bits outside that mask leave it waiting.
- R7: On a kill strobe the running context goes Inactive and its wakeup mask reads 0. Later `sig_in` strobes do not revive it. New mask writes through the registers do.
- R8: The active-status register (offset 0x44) reads bit 31 = 1 and bits [2:0] = running context index while a context runs, and reads 0 while the engine is idle.
- R9: The register at offset 0x20 selects a context. A write to offset 0x40 sets that context's program counter, which reads back at 0x40. `run_pc` shows the program counter of the running context.
- R10: Signal strobes that arrive for a context while it runs are discarded. After it yields, its pending-signal mask reads 0 and it stays Waiting without new signals.
- R11: After a yield or kill, `run_valid` is low for exactly one cycle before the next Ready context is dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register write offset |
| csr_wdata | input | 32 | Register write data |
| csr_rd_addr | input | 8 | Register read offset |
| csr_rdata | output | 32 | Register read data (combinational) |
| sig_in | input | 32 | Event signal strobes, one bit per signal line |
| yield_in | input | 1 | Running context gives up the engine and waits |
| kill_in | input | 1 | Running context terminates |
| run_valid | output | 1 | A context is executing |
| run_ctx | output | 3 | Index of the executing context |
| run_pc | output | 12 | Program counter of the executing context |

## Verification
The hardest behaviour to reach from the ports is round-robin order with several contexts Ready at once, resumed from a prior position. The bench gives every context its own wakeup bit and then raises several contexts together with one wide signal strobe. It then yields each dispatched context in turn, so a single strobe replays the whole scan order. Expected order is computed by the bench from the pending set and the last dispatched index, over a set of arithmetic masks. The non-preemption case is reached by rewriting the enable field while a context holds the engine.

// File: rtl/ctx_sched_pkg.sv
// Package: shared types and register offsets of the context scheduler.
// Assumes the enable field sits at bit 8 of its register and that at most
// eight contexts are configured so the field fits below bit 16.
package ctx_sched_pkg;

    typedef enum logic [1:0] {
        CTX_INACTIVE  = 2'd0,
        CTX_WAITING   = 2'd1,
        CTX_EXECUTING = 2'd2
    } ctx_state_e;

    localparam logic [7:0] OFS_ENABLE = 8'h18;
    localparam logic [7:0] OFS_SELECT = 8'h20;
    localparam logic [7:0] OFS_PC     = 8'h40;
    localparam logic [7:0] OFS_ACTIVE = 8'h44;
    localparam logic [7:0] OFS_SIGEV  = 8'h48;
    localparam logic [7:0] OFS_WAKE   = 8'h50;

    localparam int ENABLE_LSB = 8;

endpackage

// File: rtl/ctx_slot.sv
// Module: one context's state. Holds program counter, pending-signal mask,
// wakeup mask and Inactive/Waiting/Executing state. Assumes dispatch and
// the leave strobes are only given while they apply (dispatch when not
// executing, leave strobes only when executing).
module ctx_slot
    import ctx_sched_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pc,
    input  logic              wr_sig,
    input  logic              wr_wake,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] sig_in,
    input  logic              dispatch,
    input  logic              leave_yield,
    input  logic              leave_kill,
    output logic [PC_W-1:0]   pc_o,
    output logic [DATA_W-1:0] sig_o,
    output logic [DATA_W-1:0] wake_o,
    output logic              executing_o,
    output logic              ready_o
);

    ctx_state_e        state_q;
    logic [PC_W-1:0]   pc_q;
    logic [DATA_W-1:0] sig_q;
    logic [DATA_W-1:0] wake_q;

    // State transitions: dispatch to executing, kill to inactive, yield to waiting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTX_INACTIVE;
        end else if (dispatch) begin
            state_q <= CTX_EXECUTING;
        end else if (state_q == CTX_EXECUTING && leave_kill) begin
            state_q <= CTX_INACTIVE;
        end else if (state_q == CTX_EXECUTING && leave_yield) begin
            state_q <= CTX_WAITING;
        end
    end

    // Program counter: loaded only by a register write
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (wr_pc) pc_q <= wdata[PC_W-1:0];
    end

    // Wakeup mask: register write, erased by a kill
    always_ff @(posedge clk) begin
        if (!rst_n)                                  wake_q <= '0;
        else if (wr_wake)                            wake_q <= wdata;
        else if (state_q == CTX_EXECUTING && leave_kill) wake_q <= '0;
    end

    // Pending signals: write, cleared at dispatch and while running, else accumulate
    always_ff @(posedge clk) begin
        if (!rst_n)                                    sig_q <= '0;
        else if (wr_sig)                               sig_q <= wdata;
        else if (dispatch || state_q == CTX_EXECUTING) sig_q <= '0;
        else                                           sig_q <= sig_q | sig_in;
    end

    assign pc_o        = pc_q;
    assign sig_o       = sig_q;
    assign wake_o      = wake_q;
    assign executing_o = (state_q == CTX_EXECUTING);
    assign ready_o     = (state_q != CTX_EXECUTING) && (|(sig_q & wake_q));

    // R7
    kill_erases_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTX_EXECUTING && leave_kill && !wr_wake) |=> (wake_q == '0));

    // R10
    dispatch_drops_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch && !wr_sig) |=> (sig_q == '0));

    // R6
    yield_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTX_EXECUTING && leave_yield && !leave_kill && !dispatch)
            |=> (state_q == CTX_WAITING));

endmodule

// File: rtl/rr_pick.sv
// Module: round-robin picker. Returns the first requester found scanning
// upward with wrap from the index after 'last'. Purely combinational.
module rr_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);

    // Scan from farthest to nearest so the nearest requester is assigned last
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = N; k >= 1; k--) begin
            if (req[(int'(last) + k) % N]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'((int'(last) + k) % N);
            end
        end
    end

endmodule

// File: rtl/ctx_sched.sv
// Module: context scheduler top. Decodes register accesses, holds the
// enable field and context select, instantiates one slot per context and
// dispatches through a round-robin picker whenever the engine is idle.
// Assumes yield and kill strobes only matter while a context runs.
module ctx_sched
    import ctx_sched_pkg::*;
#(
    parameter int N_CTX  = 8,
    parameter int DATA_W = 32,
    parameter int PC_W   = 12,
    parameter int ADDR_W = 8,
    localparam int IW    = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    input  logic [ADDR_W-1:0] csr_rd_addr,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic [DATA_W-1:0] sig_in,
    input  logic              yield_in,
    input  logic              kill_in,
    output logic              run_valid,
    output logic [IW-1:0]     run_ctx,
    output logic [PC_W-1:0]   run_pc
);

    logic [N_CTX-1:0]  en_q;
    logic [IW-1:0]     sel_q;
    logic              busy_q;
    logic [IW-1:0]     cur_q;

    logic [N_CTX-1:0]  ready_vec;
    logic [N_CTX-1:0]  exec_vec;
    logic [N_CTX-1:0]  elig_vec;
    logic [PC_W-1:0]   pc_arr   [N_CTX];
    logic [DATA_W-1:0] sig_arr  [N_CTX];
    logic [DATA_W-1:0] wake_arr [N_CTX];
    logic              gnt_valid;
    logic [IW-1:0]     gnt_idx;
    logic              dispatch;
    logic              leave;

    assign dispatch = !busy_q && gnt_valid;
    assign leave    = busy_q && (yield_in || kill_in);
    assign elig_vec = ready_vec & en_q;

    // Enable field and context select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else if (csr_wr) begin
            if (csr_addr == OFS_ENABLE) en_q  <= csr_wdata[ENABLE_LSB +: N_CTX];
            if (csr_addr == OFS_SELECT) sel_q <= csr_wdata[IW-1:0];
        end
    end

    // Engine occupancy: set on dispatch, cleared when the runner leaves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cur_q  <= IW'(N_CTX - 1);
        end else if (dispatch) begin
            busy_q <= 1'b1;
            cur_q  <= gnt_idx;
        end else if (leave) begin
            busy_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < N_CTX; i++) begin : g_slot
        logic hit;
        assign hit = csr_wr && (sel_q == IW'(i));
        ctx_slot #(.DATA_W(DATA_W), .PC_W(PC_W)) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_pc       (hit && csr_addr == OFS_PC),
            .wr_sig      (hit && csr_addr == OFS_SIGEV),
            .wr_wake     (hit && csr_addr == OFS_WAKE),
            .wdata       (csr_wdata),
            .sig_in      (sig_in),
            .dispatch    (dispatch && gnt_idx == IW'(i)),
            .leave_yield (busy_q && cur_q == IW'(i) && yield_in),
            .leave_kill  (busy_q && cur_q == IW'(i) && kill_in),
            .pc_o        (pc_arr[i]),
            .sig_o       (sig_arr[i]),
            .wake_o      (wake_arr[i]),
            .executing_o (exec_vec[i]),
            .ready_o     (ready_vec[i])
        );
    end

    rr_pick #(.N(N_CTX)) pick_i (
        .req       (elig_vec),
        .last      (cur_q),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    // Register read multiplexer
    always_comb begin
        csr_rdata = '0;
        case (csr_rd_addr)
            OFS_ENABLE: csr_rdata[ENABLE_LSB +: N_CTX] = en_q;
            OFS_SELECT: csr_rdata[IW-1:0] = sel_q;
            OFS_PC:     csr_rdata[PC_W-1:0] = pc_arr[sel_q];
            OFS_SIGEV:  csr_rdata = sig_arr[sel_q];
            OFS_WAKE:   csr_rdata = wake_arr[sel_q];
            OFS_ACTIVE: if (busy_q) begin
                csr_rdata[DATA_W-1] = 1'b1;
                csr_rdata[IW-1:0]   = cur_q;
            end
            default:    csr_rdata = '0;
        endcase
    end

    assign run_valid = busy_q;
    assign run_ctx   = busy_q ? cur_q : '0;
    assign run_pc    = pc_arr[cur_q];

    // R4
    single_runner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exec_vec));

    // R8
    busy_matches_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q == (|exec_vec));

    // R5
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !yield_in && !kill_in) |=> (busy_q && $stable(cur_q)));

    // R11
    gap_after_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (yield_in || kill_in)) |=> !busy_q);

    // R2
    idle_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && (|elig_vec)) |=> busy_q);

endmodule

// File: tb/ctx_sched_tb.sv
module ctx_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [7:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [7:0]  csr_rd_addr = '0;
    logic [31:0] csr_rdata;
    logic [31:0] sig_in = '0;
    logic        yield_in = 1'b0;
    logic        kill_in = 1'b0;
    logic        run_valid;
    logic [2:0]  run_ctx;
    logic [11:0] run_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ctx_sched dut_i (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rd_addr(csr_rd_addr), .csr_rdata(csr_rdata),
        .sig_in(sig_in), .yield_in(yield_in), .kill_in(kill_in),
        .run_valid(run_valid), .run_ctx(run_ctx), .run_pc(run_pc)
    );

    localparam logic [7:0] A_EN = 8'h18, A_SEL = 8'h20, A_PC = 8'h40;
    localparam logic [7:0] A_ACT = 8'h44, A_SIG = 8'h48, A_WAKE = 8'h50;

    function automatic logic [11:0] pcv(input int k);
        return 12'((k * 12'h155 + 12'h0A3) & 12'hFFF);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        tick();
        csr_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        csr_rd_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic pulse_sig(input logic [31:0] m);
        sig_in = m; tick(); sig_in = '0;
    endtask

    task automatic do_yield();
        yield_in = 1'b1; tick(); yield_in = 1'b0;
    endtask

    task automatic do_kill();
        kill_in = 1'b1; tick(); kill_in = 1'b0;
    endtask

    int last_ctx = 0;

    // Raise a set of contexts at once, then follow the scan order by yielding each
    task automatic run_rr(input logic [7:0] mask);
        logic [7:0]  pend;
        logic [31:0] r;
        int          exp;
        pend = mask;
        pulse_sig({24'h0, mask});
        while (pend != 0) begin
            exp = -1;
            for (int k = 8; k >= 1; k--)
                if (pend[(last_ctx + k) % 8]) exp = (last_ctx + k) % 8;
            tick();
            chk("R4 dispatch order", {31'h0, run_valid, 1'b0} | {29'h0, run_ctx} << 0 & 32'h7 | {30'h0, run_valid, 1'b0},
                {30'h0, 1'b1, 1'b0} | 32'(exp));
            chk("R9 run_pc", {20'h0, run_pc}, {20'h0, pcv(exp)});
            rd(A_ACT, r);
            chk("R8 active status", r, 32'h8000_0000 | 32'(exp));
            do_yield();
            chk("R11 idle gap", {31'h0, run_valid}, 32'h0);
            pend[exp] = 1'b0;
            last_ctx  = exp;
        end
    endtask

    initial begin
        logic [31:0] r;
        logic [7:0]  m;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 run_valid", {31'h0, run_valid}, 32'h0);
        rd(A_ACT, r);  chk("R1 active", r, 32'h0);
        rd(A_EN, r);   chk("R1 enable", r, 32'h0);
        rd(A_WAKE, r); chk("R1 wake", r, 32'h0);
        rd(A_SIG, r);  chk("R1 sig", r, 32'h0);
        rd(A_PC, r);   chk("R1 pc", r, 32'h0);

        // R2 mask writes make context 0 ready and dispatched
        wr(A_SEL, 0);
        wr(A_WAKE, 1);
        wr(A_EN, 32'h0000_0100);
        wr(A_SIG, 1);
        chk("R2 not yet", {31'h0, run_valid}, 32'h0);
        tick();
        chk("R2 dispatched", {28'h0, run_valid, run_ctx}, 32'h8);
        rd(A_ACT, r); chk("R8 active ctx0", r, 32'h8000_0000);
        do_yield();
        chk("R11 idle after yield", {31'h0, run_valid}, 32'h0);
        last_ctx = 0;

        // R9 program counter sweep and wakeup setup for every context
        for (int k = 0; k < 8; k++) begin
            wr(A_SEL, 32'(k));
            wr(A_PC, {20'h0, pcv(k)});
            wr(A_WAKE, 32'h1 << k);
            rd(A_PC, r);
            chk("R9 pc readback", r, {20'h0, pcv(k)});
        end
        wr(A_EN, 32'h0000_FF00);

        // R4 round-robin sweep over arithmetic subsets
        for (int t = 0; t < 8; t++) begin
            m = 8'((t * 73 + 8'h2D) & 8'hFF);
            if (m == 0) m = 8'h81;
            run_rr(m);
        end
        run_rr(8'hFF);

        // R10 signals during execution are dropped
        pulse_sig(32'h8);
        tick();
        chk("R10 ctx3 runs", {28'h0, run_valid, run_ctx}, 32'hB);
        pulse_sig(32'h8);
        chk("R10 still ctx3", {28'h0, run_valid, run_ctx}, 32'hB);
        do_yield();
        repeat (3) tick();
        chk("R10 stays waiting", {31'h0, run_valid}, 32'h0);
        wr(A_SEL, 3); rd(A_SIG, r);
        chk("R10 sig mask empty", r, 32'h0);

        // R5 disabling the runner does not preempt it
        pulse_sig(32'h20);
        tick();
        chk("R5 ctx5 runs", {28'h0, run_valid, run_ctx}, 32'hD);
        wr(A_EN, 32'h0000_DF00);
        for (int k = 0; k < 4; k++) begin
            chk("R5 holds", {28'h0, run_valid, run_ctx}, 32'hD);
            tick();
        end
        do_yield();
        // R3 ready but disabled is not dispatched
        pulse_sig(32'h20);
        tick(); tick();
        chk("R3 disabled waits", {31'h0, run_valid}, 32'h0);
        wr(A_EN, 32'h0000_FF00);
        chk("R3 not yet", {31'h0, run_valid}, 32'h0);
        tick();
        chk("R3 enabled runs", {28'h0, run_valid, run_ctx}, 32'hD);
        do_yield();

        // R7 kill erases masks and ignores later signals
        pulse_sig(32'h40);
        tick();
        chk("R7 ctx6 runs", {28'h0, run_valid, run_ctx}, 32'hE);
        do_kill();
        chk("R7 idle after kill", {31'h0, run_valid}, 32'h0);
        wr(A_SEL, 6); rd(A_WAKE, r);
        chk("R7 wake erased", r, 32'h0);
        pulse_sig(32'h40);
        tick(); tick();
        chk("R7 stays inactive", {31'h0, run_valid}, 32'h0);
        wr(A_WAKE, 32'h40);
        wr(A_SIG, 32'h40);
        tick();
        chk("R7 revived", {28'h0, run_valid, run_ctx}, 32'hE);
        do_yield();

        // R6 only a matching signal wakes a waiting context
        pulse_sig(32'h0000_0200);
        tick(); tick();
        chk("R6 non-matching ignored", {31'h0, run_valid}, 32'h0);
        pulse_sig(32'h4);
        tick();
        chk("R6 matching wakes", {28'h0, run_valid, run_ctx}, 32'hA);
        do_yield();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule